// File: doc/BRIEF.md
# Two-Group Prescaled Tick Generator

This block turns one system clock into count-enable pulses for five timer channels. No clock is derived: every output is a single-cycle enable that a downstream counter samples on the same system clock. Two programmable 8-bit prescalers form the first stage. The first one drives channels 0 and 1, and the second one drives channels 2, 3 and 4.

Each channel has its own second stage. That stage either divides its group's prescaler tick by a power-of-two ratio or follows an external clock pin. The external pin is synchronized inside the block and then edge-detected. Software-visible registers and the timer counters themselves sit outside this block. Their settings reach it as the plain input vectors `pre0_val`, `pre1_val` and `div_sel`.

Top module: `tick_gen`

## Requirements
- R1: While `rst_n` is low, every bit of `ch_tick` is 0. After release, no channel ticks before its first scheduled tick as defined in R3.
- R2: A prescaler holding value p (0 to 255) produces one internal tick every p+1 system clocks. Its counter is cleared by reset, so its first tick falls in the first cycle after reset release.
- R3: Channels 0 and 1 take their ticks from the prescaler set by `pre0_val`. Channels 2, 3 and 4 use the one set by `pre1_val`. The m-th prescaler tick after release (m counted from 0) occurs in cycle m·(p+1). A channel in divide mode with ratio r first shows `ch_tick` high in the cycle after prescaler tick m = r−1.
- R4: A channel's 3-bit select field is `div_sel[3*i+2:3*i]`. Codes 0, 1, 2 and 3 give ratios 2, 4, 8 and 16. With the settings held stable, consecutive channel ticks are (p+1)·ratio clocks apart.
- R5: A prescaler value of 15 with code 2 gives one channel tick every 128 system clocks.
- R6: A new prescaler value is taken only when that prescaler's counter wraps. The period already running finishes at its old length.
- R7: Select codes 4 to 7 put a channel in external mode. In this mode, `ext_clk` passes through a two-flop synchronizer. A value that goes high ahead of clock edge e0 gives one tick that is visible for the cycle after edge e2.
- R8: Each channel tick is high for exactly one system clock.
- R9: An external-mode channel does not tick while `ext_clk` has no rising edge, even though its prescaler keeps running. A divide-mode channel keeps its R4 spacing while `ext_clk` toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| pre0_val | input | 8 | Reload value of the prescaler for channels 0–1 |
| pre1_val | input | 8 | Reload value of the prescaler for channels 2–4 |
| div_sel | input | 15 | Three-bit ratio/source select per channel, channel i at bits 3i+2:3i |
| ext_clk | input | 1 | Asynchronous external clock, shared by all channels in external mode |
| ch_tick | output | 5 | One-cycle count enable per channel |

## Verification
The divide path is swept over four pairs of prescaler values with each select code rotated across all five channels. The two groups always get different values, so a channel wired to the wrong prescaler shows up as a wrong spacing. In every configuration, both the position of the first tick and the spacing of the ticks that follow are compared against (p+1)·ratio. These two checks separate a wrong ratio, an off-by-one count and a wrong counter phase. A mid-run prescaler change separates a reload that waits for the wrap (expected spacings 14, 8, 8) from one that truncates the running period. Isolated external pulses pin the synchronizer latency to exactly three edges and show that no tick appears without an edge. During the same run, a neighbouring divide-mode channel must keep its spacing.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;
  localparam int SEL_W   = 3;
  localparam int RATIO_W = 2;                 // bits of the ratio part of a code
  localparam int DIV_W   = 1 << RATIO_W;      // divider counter width, max ratio 2**DIV_W

  typedef enum logic [SEL_W-1:0] {
    SEL_DIV2  = 3'd0,
    SEL_DIV4  = 3'd1,
    SEL_DIV8  = 3'd2,
    SEL_DIV16 = 3'd3,
    SEL_EXT   = 3'd4
  } div_sel_e;

  function automatic logic sel_is_ext(input logic [SEL_W-1:0] s);
    return s[SEL_W-1];
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] load_val,
  output logic          tick
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;

  assign tick = (cnt_q == '0);

  always_comb begin
    if (tick) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && load_val != '0) |=> !tick);                         // R2

  AST_PRE_NO_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (cnt_q < $past(cnt_q)));                           // R6
endmodule

// File: rtl/tick_ext_sync.sv
module tick_ext_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic rise
);
  logic meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      meta_q <= ext_in;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign rise = sync_q & ~hist_q;

  AST_EXT_RISE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);                                             // R7
endmodule

// File: rtl/tick_chan_div.sv
module tick_chan_div
  import tick_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_tick,
  input  logic             ext_rise,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [DIV_W-1:0]   cnt_q, cnt_d;
  logic               cnt_en;
  logic [DIV_W-1:0]   mask;
  logic [RATIO_W-1:0] shamt;
  logic               ext_mode;
  logic               hit_pre;
  logic               tick_q, tick_d;

  assign ext_mode = sel_is_ext(sel);
  assign shamt    = RATIO_W'(DIV_W - 1) - sel[RATIO_W-1:0];
  assign mask     = {DIV_W{1'b1}} >> shamt;
  assign hit_pre  = pre_tick && ((cnt_q & mask) == mask);

  always_comb begin
    cnt_en = pre_tick;
    cnt_d  = cnt_q + 1'b1;
    tick_d = ext_mode ? ext_rise : hit_pre;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_d;
  end

  assign tick = tick_q;

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && $stable(sel)) |=> !tick_q);                       // R8

  AST_DIV_FROM_PRESCALER: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && !ext_mode && $stable(sel)) |-> $past(pre_tick));  // R4

  AST_EXT_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && ext_mode && $stable(sel)) |-> $past(ext_rise));   // R7
endmodule

// File: rtl/tick_gen.sv
module tick_gen
  import tick_gen_pkg::*;
#(
  parameter int NUM_CH  = 5,
  parameter int GRP0_CH = 2,
  parameter int PW      = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PW-1:0]           pre0_val,
  input  logic [PW-1:0]           pre1_val,
  input  logic [NUM_CH*SEL_W-1:0] div_sel,
  input  logic                    ext_clk,
  output logic [NUM_CH-1:0]       ch_tick
);
  localparam int NUM_GRP = 2;

  logic [NUM_GRP-1:0] pre_tick;
  logic [PW-1:0]      pre_val [NUM_GRP];
  logic               ext_rise;

  assign pre_val[0] = pre0_val;
  assign pre_val[1] = pre1_val;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
    tick_prescaler #(.PW(PW)) i_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_val (pre_val[g]),
      .tick     (pre_tick[g])
    );
  end

  tick_ext_sync i_ext (
    .clk    (clk),
    .rst_n  (rst_n),
    .ext_in (ext_clk),
    .rise   (ext_rise)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int GRP = (i < GRP0_CH) ? 0 : 1;
    tick_chan_div i_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .pre_tick (pre_tick[GRP]),
      .ext_rise (ext_rise),
      .sel      (div_sel[i*SEL_W +: SEL_W]),
      .tick     (ch_tick[i])
    );
  end

  AST_GRP0_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_tick[0] && !div_sel[SEL_W-1] && $stable(div_sel)) |-> $past(pre_tick[0]));  // R3

  AST_GRP1_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_tick[NUM_CH-1] && !div_sel[NUM_CH*SEL_W-1] && $stable(div_sel))
      |-> $past(pre_tick[1]));                                                       // R3
endmodule

// File: tb/test_tick_gen.sv
module test_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    pre0_val = '0;
  logic [7:0]    pre1_val = '0;
  logic [14:0]   div_sel = '0;
  logic          ext_clk = 1'b0;
  logic [NCH-1:0] ch_tick;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_gen i_tick_gen (
    .clk(clk), .rst_n(rst_n), .pre0_val(pre0_val), .pre1_val(pre1_val),
    .div_sel(div_sel), .ext_clk(ext_clk), .ch_tick(ch_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(ch_tick == '0, "R1 outputs low in reset", int'(ch_tick), 0);
    rst_n = 1'b1;
  endtask

  // Sweep: group values p0/p1, code of channel i = (i+rot)%4
  task automatic run_cfg(input int p0, input int p1, input int rot);
    int last [NCH];
    int cnt  [NCH];
    int per  [NCH];
    int pmax;
    pre0_val = 8'(p0);
    pre1_val = 8'(p1);
    pmax = 0;
    for (int i = 0; i < NCH; i++) begin
      int code = (i + rot) % 4;
      int p    = (i < 2) ? p0 : p1;
      div_sel[i*3 +: 3] = 3'(code);
      per[i]  = (p + 1) << (code + 1);
      last[i] = 0;
      cnt[i]  = 0;
      if (per[i] > pmax) pmax = per[i];
    end
    do_reset();
    for (int s = 1; s <= 3*pmax + 20; s++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
        if (ch_tick[i]) begin
          if (cnt[i] == 0)
            check(s == per[i] - ((i < 2) ? p0 : p1), "R3 first tick sample", s,
                  per[i] - ((i < 2) ? p0 : p1));
          else if (per[i] == 128 && ((i < 2) ? p0 : p1) == 15)
            check(s - last[i] == 128, "R5 p=15 code 2 spacing", s - last[i], 128);
          else
            check(s - last[i] == per[i], "R4 tick spacing", s - last[i], per[i]);
          if (cnt[i] > 0)
            check(s - last[i] > 1, "R8 single-cycle tick", s - last[i], 2);
          last[i] = s;
          cnt[i]++;
        end
      end
    end
    for (int i = 0; i < NCH; i++)
      check(cnt[i] >= 3, "R2 tick count in window", cnt[i], 3);
  endtask

  task automatic run_reload();
    int last, k, s;
    int exp_sp [3] = '{14, 8, 8};
    pre0_val = 8'd9;
    pre1_val = 8'd0;
    div_sel  = '0;
    do_reset();
    s = 0;
    while (!ch_tick[0] && s < 100) begin
      @(negedge clk);
      s++;
    end
    pre0_val = 8'd3;   // change right after a tick: period in flight is 10
    last = s;
    k = 0;
    while (k < 3 && s < 200) begin
      @(negedge clk);
      s++;
      if (ch_tick[0]) begin
        check(s - last == exp_sp[k], "R6 reload at wrap", s - last, exp_sp[k]);
        last = s;
        k++;
      end
    end
    check(k == 3, "R6 ticks after reload", k, 3);
  endtask

  task automatic run_ext();
    int last1 = 0;
    int s = 0;
    logic [NCH-1:0] ext_mask = 5'b10101;
    pre0_val = 8'd0;
    pre1_val = 8'd0;
    div_sel  = {3'd4, 3'd1, 3'd7, 3'd0, 3'd4};   // ch4..ch0
    ext_clk  = 1'b0;
    do_reset();
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); s++;
      if (ch_tick[1]) begin
        if (last1 > 0) check(s - last1 == 2, "R9 divide channel undisturbed", s - last1, 2);
        last1 = s;
      end
      check((ch_tick & ext_mask) == '0, "R9 no tick without edge", int'(ch_tick & ext_mask), 0);
    end
    for (int e = 0; e < 6; e++) begin
      ext_clk = 1'b1;
      for (int j = 1; j <= 7; j++) begin
        @(negedge clk); s++;
        if (ch_tick[1]) begin
          if (last1 > 0) check(s - last1 == 2, "R9 divide channel undisturbed", s - last1, 2);
          last1 = s;
        end
        if (j == 3) begin
          check((ch_tick & ext_mask) == ext_mask, "R7 tick three edges after rise",
                int'(ch_tick & ext_mask), int'(ext_mask));
          ext_clk = 1'b0;
        end else begin
          check((ch_tick & ext_mask) == '0, "R7 R8 no tick off the edge",
                int'(ch_tick & ext_mask), 0);
        end
      end
    end
  endtask

  initial begin
    int pa [4] = '{0, 1, 4, 15};
    int pb [4] = '{3, 0, 15, 2};
    for (int k = 0; k < 4; k++)
      for (int r = 0; r < 4; r++)
        run_cfg(pa[k], pb[k], r);
    run_reload();
    run_ext();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule